// File: doc/BRIEF.md
# Scrolling Display Row Mapper

This block turns the position of the pixel being scanned into an address of a bit-mapped frame memory of 128 columns by 65 rows. The scan engine presents a common-line index and a segment (column) index. One clock later the mapper returns the memory row and column that hold that pixel. The row is offset by a programmable first-line value and wraps around the 65-row height, so software scrolls the picture vertically by writing a single value. Two independent mirror settings flip the picture in the column direction, the row direction, or both.

Configuration writes land in pending registers. The mapper copies them into the working set only when a scan of common line 0 arrives, so a frame is never drawn with two different offsets or orientations. The wraparound uses one compare and one conditional subtract rather than a divider. The memory array and the panel drive timing sit outside the block.

Top module: `scroll_row_mapper`

## Requirements
- R1: After reset, out_valid is low, the pending and working first-line values are 0 and both mirrors are off, so the first frame maps line L, column C to row L, column C.
- R2: For an accepted scan of line L with working first line S and no row mirror, ram_row equals (L + S) mod 65. ram_row is always below 65 and appears one clock after the scan is presented.
- R3: A first-line value of 56 (0x38) wraps correctly: line 8 maps to row 64, line 9 to row 0 and line 64 to row 55.
- R4: With the column mirror on, ram_col equals 127 minus scan_col. With it off, ram_col equals scan_col.
- R5: With the row mirror on, the line index L is replaced by 64 minus L before the first-line offset is added.
- R6: A first-line write with a value of 65 or more is ignored. The pending value keeps what it held, and this shows at the next frame.
- R7: Writes to the first line (start_wr with start_val) and to the mirrors (mirror_wr with mirror_col as the column flip and mirror_row as the row flip) take effect at the next scan of line 0. That scan already uses the new settings. Scans of any other line keep using the settings that were in force before.
- R8: A scan with scan_line of 65 or more produces no result: out_valid stays low one clock later.
- R9: out_valid is high exactly one clock after a cycle with scan_valid high and scan_line below 65.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Write strobe for the pending first-line value |
| start_val | input | 7 | First-line value to write (0 to 64 accepted) |
| mirror_wr | input | 1 | Write strobe for both pending mirror flags |
| mirror_col | input | 1 | Pending column-flip value |
| mirror_row | input | 1 | Pending row-flip value |
| scan_valid | input | 1 | A scan position is presented this cycle |
| scan_line | input | 7 | Common-line index being scanned |
| scan_col | input | 7 | Segment (column) index being scanned |
| out_valid | output | 1 | ram_row and ram_col hold a result |
| ram_row | output | 7 | Frame-memory row address |
| ram_col | output | 7 | Frame-memory column address |

## Verification
The bench builds the mapper with its default geometry of 128 columns and 65 rows. With that geometry every wrap boundary can be reached directly: the last row 64, the mirrored line 64 minus L, the 0x38 offset that pushes lines across the 65-row seam, and the line values 65 and above that must be dropped. The scoreboard model applies each write to its own pending copy and copies that into the working copy only when it drives line 0. Every scan before and after a frame boundary therefore tests the deferral, including the case where a rejected write leaves the old offset in place.

// File: rtl/smap_pkg.sv
package smap_pkg;

  localparam int DEF_COLS = 128;
  localparam int DEF_ROWS = 65;

  // Add two indices already below m and fold the sum back into [0, m)
  // with one compare and one subtract; both inputs are below m.
  function automatic int wrap_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

  // Reflect an index across a span of n entries.
  function automatic int reflect_idx(input int i, input int n);
    return (n - 1) - i;
  endfunction

endpackage

// File: rtl/smap_cfg_regs.sv
module smap_cfg_regs #(
  parameter int NUM_ROWS = smap_pkg::DEF_ROWS,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic [ROW_W-1:0] start_val,
  input  logic             mirror_wr,
  input  logic             mirror_col,
  input  logic             mirror_row,
  input  logic             frame_start,
  output logic [ROW_W-1:0] pend_start,
  output logic [ROW_W-1:0] act_start,
  output logic [ROW_W-1:0] eff_start,
  output logic             eff_colm,
  output logic             eff_rowm,
  output logic             start_accept
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic pend_colm, pend_rowm;
  logic act_colm, act_rowm;

  assign start_accept = start_wr && (start_val <= LAST_ROW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_start <= '0;
      pend_colm  <= 1'b0;
      pend_rowm  <= 1'b0;
      act_start  <= '0;
      act_colm   <= 1'b0;
      act_rowm   <= 1'b0;
    end else begin
      if (start_accept) pend_start <= start_val;
      if (mirror_wr) begin
        pend_colm <= mirror_col;
        pend_rowm <= mirror_row;
      end
      if (frame_start) begin
        act_start <= pend_start;
        act_colm  <= pend_colm;
        act_rowm  <= pend_rowm;
      end
    end
  end

  // Line 0 of a frame already sees the settings it is committing.
  assign eff_start = frame_start ? pend_start : act_start;
  assign eff_colm  = frame_start ? pend_colm  : act_colm;
  assign eff_rowm  = frame_start ? pend_rowm  : act_rowm;

endmodule

// File: rtl/smap_row_calc.sv
module smap_row_calc #(
  parameter int NUM_ROWS = smap_pkg::DEF_ROWS,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic [ROW_W-1:0] line_in,
  input  logic [ROW_W-1:0] first_line,
  input  logic             flip,
  output logic             line_ok,
  output logic [ROW_W-1:0] row_out
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic [ROW_W-1:0] oriented;

  assign line_ok = (line_in <= LAST_ROW);

  always_comb begin
    oriented = line_in;
    if (flip) oriented = ROW_W'(smap_pkg::reflect_idx(int'(line_in), NUM_ROWS));
    if (!line_ok) oriented = '0;
  end

  assign row_out = ROW_W'(smap_pkg::wrap_add(int'(oriented), int'(first_line), NUM_ROWS));

endmodule

// File: rtl/smap_col_calc.sv
module smap_col_calc #(
  parameter int NUM_COLS = smap_pkg::DEF_COLS,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic [COL_W-1:0] col_in,
  input  logic             flip,
  output logic [COL_W-1:0] col_out
);

  assign col_out = flip ? COL_W'(smap_pkg::reflect_idx(int'(col_in), NUM_COLS)) : col_in;

endmodule

// File: rtl/scroll_row_mapper.sv
module scroll_row_mapper #(
  parameter int NUM_COLS = smap_pkg::DEF_COLS,
  parameter int NUM_ROWS = smap_pkg::DEF_ROWS,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic [ROW_W-1:0] start_val,
  input  logic             mirror_wr,
  input  logic             mirror_col,
  input  logic             mirror_row,
  input  logic             scan_valid,
  input  logic [ROW_W-1:0] scan_line,
  input  logic [COL_W-1:0] scan_col,
  output logic             out_valid,
  output logic [ROW_W-1:0] ram_row,
  output logic [COL_W-1:0] ram_col
);

  logic             frame_start;
  logic             line_ok;
  logic             scan_take;
  logic             start_accept;
  logic [ROW_W-1:0] pend_start, act_start, eff_start;
  logic             eff_colm, eff_rowm;
  logic [ROW_W-1:0] row_next;
  logic [COL_W-1:0] col_next;

  assign frame_start = scan_valid && (scan_line == '0);

  smap_cfg_regs #(.NUM_ROWS(NUM_ROWS)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_val(start_val),
    .mirror_wr(mirror_wr), .mirror_col(mirror_col), .mirror_row(mirror_row),
    .frame_start(frame_start),
    .pend_start(pend_start), .act_start(act_start), .eff_start(eff_start),
    .eff_colm(eff_colm), .eff_rowm(eff_rowm), .start_accept(start_accept)
  );

  smap_row_calc #(.NUM_ROWS(NUM_ROWS)) row_i (
    .line_in(scan_line), .first_line(eff_start), .flip(eff_rowm),
    .line_ok(line_ok), .row_out(row_next)
  );

  smap_col_calc #(.NUM_COLS(NUM_COLS)) col_i (
    .col_in(scan_col), .flip(eff_colm), .col_out(col_next)
  );

  assign scan_take = scan_valid && line_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ram_row   <= '0;
      ram_col   <= '0;
    end else begin
      out_valid <= scan_take;
      if (scan_take) begin
        ram_row <= row_next;
        ram_col <= col_next;
      end
    end
  end

endmodule

// File: rtl/scroll_row_mapper_chk.sv
module scroll_row_mapper_chk #(
  parameter int NUM_COLS = smap_pkg::DEF_COLS,
  parameter int NUM_ROWS = smap_pkg::DEF_ROWS,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_valid,
  input logic [ROW_W-1:0] scan_line,
  input logic [COL_W-1:0] scan_col,
  input logic             frame_start,
  input logic [ROW_W-1:0] pend_start,
  input logic [ROW_W-1:0] act_start,
  input logic [ROW_W-1:0] eff_start,
  input logic             eff_colm,
  input logic             eff_rowm,
  input logic             out_valid,
  input logic [ROW_W-1:0] ram_row,
  input logic [COL_W-1:0] ram_col
);

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(ram_row) < NUM_ROWS)); // R2

  AST_PLAIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && int'(scan_line) < NUM_ROWS && !eff_rowm && eff_start == '0)
      |=> (out_valid && ram_row == $past(scan_line))); // R2

  AST_COL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && int'(scan_line) < NUM_ROWS && eff_colm)
      |=> (int'(ram_col) + int'($past(scan_col)) == NUM_COLS - 1)); // R4

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_start) < NUM_ROWS); // R6

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_start)); // R7

  AST_DROP_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && int'(scan_line) >= NUM_ROWS) |=> !out_valid); // R8

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && int'(scan_line) < NUM_ROWS) |=> out_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_valid |=> !out_valid); // R9

endmodule

bind scroll_row_mapper scroll_row_mapper_chk #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .scan_valid(scan_valid), .scan_line(scan_line), .scan_col(scan_col),
  .frame_start(frame_start), .pend_start(pend_start), .act_start(act_start),
  .eff_start(eff_start), .eff_colm(eff_colm), .eff_rowm(eff_rowm),
  .out_valid(out_valid), .ram_row(ram_row), .ram_col(ram_col)
);

// File: tb/scroll_row_mapper_tb_top.sv
`timescale 1ns/1ps
module scroll_row_mapper_tb_top;

  localparam int NC = 128;
  localparam int NR = 65;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_wr = 1'b0;
  logic [6:0] start_val = '0;
  logic       mirror_wr = 1'b0;
  logic       mirror_col = 1'b0;
  logic       mirror_row = 1'b0;
  logic       scan_valid = 1'b0;
  logic [6:0] scan_line = '0;
  logic [6:0] scan_col = '0;
  logic       out_valid;
  logic [6:0] ram_row;
  logic [6:0] ram_col;

  always #4 clk = ~clk;

  scroll_row_mapper #(.NUM_COLS(NC), .NUM_ROWS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .start_val(start_val),
    .mirror_wr(mirror_wr), .mirror_col(mirror_col), .mirror_row(mirror_row),
    .scan_valid(scan_valid), .scan_line(scan_line), .scan_col(scan_col),
    .out_valid(out_valid), .ram_row(ram_row), .ram_col(ram_col)
  );

  typedef struct {
    int    stamp;
    bit    v;
    int    row;
    int    col;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  int p_start = 0, a_start = 0;
  bit p_cm = 0, p_rm = 0, a_cm = 0, a_rm = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each result against the scoreboard front.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].stamp == cyc) begin
        it = q.pop_front();
        checks++;
        if (out_valid !== it.v) begin
          errors++;
          $display("FAIL %s: out_valid=%0b expected %0b", it.tag, out_valid, it.v);
        end else if (it.v && (int'(ram_row) != it.row || int'(ram_col) != it.col)) begin
          errors++;
          $display("FAIL %s: row=%0d col=%0d expected row=%0d col=%0d",
                   it.tag, ram_row, ram_col, it.row, it.col);
        end
      end else if (out_valid === 1'b1) begin
        checks++;
        errors++;
        $display("FAIL R9: out_valid=1 expected 0 with no scan pending");
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    scan_valid = 1'b0; start_wr = 1'b0; mirror_wr = 1'b0;
  endtask

  task automatic set_start(input int v);
    @(posedge clk); #1;
    scan_valid = 1'b0; mirror_wr = 1'b0;
    start_wr = 1'b1; start_val = 7'(v);
    if (v < NR) p_start = v;
    @(posedge clk); #1;
    start_wr = 1'b0;
  endtask

  task automatic set_mirror(input bit c, input bit r);
    @(posedge clk); #1;
    scan_valid = 1'b0; start_wr = 1'b0;
    mirror_wr = 1'b1; mirror_col = c; mirror_row = r;
    p_cm = c; p_rm = r;
    @(posedge clk); #1;
    mirror_wr = 1'b0;
  endtask

  // Driver: present one scan and push the expected result.
  task automatic scan(input int line, input int col, input string tag);
    exp_t e;
    int l;
    @(posedge clk); #1;
    start_wr = 1'b0; mirror_wr = 1'b0;
    scan_valid = 1'b1; scan_line = 7'(line); scan_col = 7'(col);
    if (line == 0) begin
      a_start = p_start; a_cm = p_cm; a_rm = p_rm;
    end
    e.stamp = cyc + 1;
    e.tag = tag;
    e.v = (line < NR);
    l = a_rm ? (NR - 1 - line) : line;
    e.row = (l + a_start) % NR;
    e.col = a_cm ? (NC - 1 - col) : col;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%0b after reset expected 0", out_valid);
    end

    // R1 / R2 / R9: identity mapping after reset, back-to-back scans
    scan(0, 0, "R1");
    scan(1, 5, "R2");
    scan(30, 127, "R9");
    scan(64, 64, "R2");
    idle();

    // R7: new offset waits for line 0
    set_start(56);
    scan(5, 3, "R7");
    scan(0, 3, "R7");
    // R3: wrap across the 65-row seam with offset 0x38
    scan(8, 1, "R3");
    scan(9, 2, "R3");
    scan(64, 3, "R3");
    idle();

    // R6: out-of-range write ignored
    set_start(70);
    scan(0, 0, "R6");
    scan(1, 0, "R6");
    set_start(127);
    scan(0, 9, "R6");
    idle();

    // R8: line indices at and beyond the height are dropped
    scan(65, 0, "R8");
    scan(100, 0, "R8");
    scan(2, 0, "R8");
    idle();

    // R4: column mirror, deferred to line 0
    set_mirror(1'b1, 1'b0);
    scan(3, 10, "R7");
    scan(0, 0, "R4");
    scan(4, 100, "R4");
    scan(5, 127, "R4");
    idle();

    // R5: row mirror with and without offset
    set_mirror(1'b0, 1'b1);
    set_start(0);
    scan(0, 7, "R5");
    scan(64, 7, "R5");
    scan(20, 7, "R5");
    set_start(10);
    scan(0, 1, "R5");
    scan(60, 1, "R5");
    idle();

    // R7: both mirrors and offset commit together
    set_mirror(1'b1, 1'b1);
    set_start(40);
    scan(33, 20, "R7");
    scan(0, 20, "R7");
    scan(33, 20, "R7");
    idle();

    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", q.size());
    end
    finish_run();
  end

endmodule